// File: doc/BRIEF.md
# Protected Top-of-RAM Segment Access Filter

This block sits between a CPU memory port and system RAM. It guards a window at the very top of RAM that is reserved for system management mode. Two byte-wide configuration registers are written over a simple register port. The sizing register enables the segment and selects its size from a two-bit code. The control register holds the global enable, close, open and lock bits.

Each CPU request carries an address, a direction, write data and a flag that marks a system-management access. The filter either passes the request unchanged to RAM or blocks it. A blocked read returns all-ones data and sends nothing to RAM. A blocked write is dropped.

Sizes are counted in size units of 2^UNIT_LOG2 bytes. RAM holds RAM_UNITS such units, and RAM_UNITS is a power of two. The window covers the top `units` size units, so its first byte lies at (RAM_UNITS - units) * 2^UNIT_LOG2.

Top module: `tseg_access_filter`

## Requirements
- R1: After reset, both registers read back 0: size code 00, segment enable clear and every control bit clear. No access is blocked.
- R2: In the sizing register, bit 0 enables the segment and bits [2:1] hold the size code. Code 00 selects 1 unit, code 01 selects 2 units and code 10 selects 8 units. The window starts at (RAM_UNITS - units) size units.
- R3: Size code 11 selects a window of EXT_UNITS size units.
- R4: Any byte below the window base, including the byte just below it, is passed to RAM, so a written value reads back unchanged.
- R5: A read is blocked when it is not flagged system-management, its address is at or above the base, and the segment is active and not open. A blocked read returns 0xFF, and ram_valid stays low.
- R6: A blocked write does not reach RAM. A later non-system-management read of that byte returns 0xFF, and a system-management read of it returns the old contents.
- R7: The segment is active only when the global enable (control bit 0) and the segment enable (sizing bit 0) are both set.
- R8: Accesses flagged system-management always reach RAM, whatever the state of open, close and lock.
- R9: Control bit 2 (open) with bit 1 (close) clear lets non-system-management accesses through. Open together with close blocks them, and so does having neither bit set.
- R10: Once control bit 3 (lock) is set, the following hold until reset:
  - Writes to the sizing register are ignored.
  - Writes to the global enable and open bits are ignored.
  - Lock stays set.
  - Close remains writable.
- R11: A register write captured on clock edge N changes the filtering of accesses only from clock edge N+1 onward.
- R12: cfg_rdata shows the sizing register when cfg_sel=0 and the control register when cfg_sel=1. Bits with no function read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | Register select: 0 sizing, 1 control |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Contents of the selected register |
| cpu_valid | input | 1 | CPU request valid |
| cpu_we | input | 1 | CPU request is a write |
| cpu_smm | input | 1 | Request issued in system management mode |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_rdata | output | DATA_W | Read data returned to the CPU |
| ram_valid | output | 1 | Request forwarded to RAM |
| ram_we | output | 1 | Forwarded request is a write |
| ram_addr | output | ADDR_W | Address to RAM |
| ram_wdata | output | DATA_W | Write data to RAM |
| ram_rdata | input | DATA_W | Read data from RAM |

## Verification
The hardest state to reach from the ports is a locked segment that receives register writes trying to move, disable or open it. Reaching it takes the full programming order: size first, then close and enable, then lock in a separate write. The bench follows that order and then issues the hostile writes. Because RAM is a bench array, the bench can look behind a dropped write with a system-management read and see that the byte is unchanged. The bench also sweeps every byte address for each size code on a small configuration, which covers the base boundary exactly.

// File: rtl/tseg_filter_pkg.sv
package tseg_filter_pkg;
  localparam int CFG_W = 8;

  // Sizing register fields.
  localparam int SZ_EN_BIT = 0;
  localparam int SZ_CODE_LO = 1;
  localparam int SZ_CODE_HI = 2;

  // Control register fields.
  localparam int CT_GEN_BIT = 0;
  localparam int CT_CLOSE_BIT = 1;
  localparam int CT_OPEN_BIT = 2;
  localparam int CT_LOCK_BIT = 3;

  typedef enum logic [1:0] {
    SZ_ONE   = 2'b00,
    SZ_TWO   = 2'b01,
    SZ_EIGHT = 2'b10,
    SZ_EXT   = 2'b11
  } size_code_e;

  function automatic int unsigned units_for(input logic [1:0] code, input int unsigned ext_units);
    case (size_code_e'(code))
      SZ_ONE:   return 1;
      SZ_TWO:   return 2;
      SZ_EIGHT: return 8;
      default:  return ext_units;
    endcase
  endfunction
endpackage

// File: rtl/tseg_cfg_regs.sv
module tseg_cfg_regs
  import tseg_filter_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic             cfg_sel,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] size_q,
  output logic [CFG_W-1:0] ctrl_q,
  output logic             cfg_changed_q
);
  logic [CFG_W-1:0] size_d;
  logic [CFG_W-1:0] ctrl_d;
  logic             locked;

  assign locked = ctrl_q[CT_LOCK_BIT];

  always_comb begin
    size_d = size_q;
    ctrl_d = ctrl_q;
    if (cfg_we) begin
      if (!cfg_sel) begin
        if (!locked) begin
          size_d = '0;
          size_d[SZ_CODE_HI:SZ_EN_BIT] = cfg_wdata[SZ_CODE_HI:SZ_EN_BIT];
        end
      end else if (locked) begin
        ctrl_d[CT_CLOSE_BIT] = cfg_wdata[CT_CLOSE_BIT];
      end else begin
        ctrl_d = '0;
        ctrl_d[CT_LOCK_BIT:CT_GEN_BIT] = cfg_wdata[CT_LOCK_BIT:CT_GEN_BIT];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_q <= '0;
      ctrl_q <= '0;
      cfg_changed_q <= 1'b0;
    end else begin
      cfg_changed_q <= cfg_we;
      if (cfg_we) begin
        size_q <= size_d;
        ctrl_q <= ctrl_d;
      end
    end
  end
endmodule

// File: rtl/tseg_window_decode.sv
module tseg_window_decode
  import tseg_filter_pkg::*;
#(
  parameter int RAM_UNITS = 128,
  parameter int UNIT_LOG2 = 20,
  parameter int EXT_UNITS = 16,
  parameter int ADDR_W    = 27
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [CFG_W-1:0]  size_q,
  input  logic [CFG_W-1:0]  ctrl_q,
  output logic [ADDR_W-1:0] base_q,
  output logic              active_q,
  output logic              open_q
);
  localparam int unsigned RESET_SPAN = (RAM_UNITS - 1) << UNIT_LOG2;
  localparam logic [ADDR_W-1:0] RESET_BASE = RESET_SPAN[ADDR_W-1:0];

  int unsigned units;
  int unsigned span;
  logic [ADDR_W-1:0] base_d;
  logic active_d;
  logic open_d;

  always_comb begin
    units = units_for(size_q[SZ_CODE_HI:SZ_CODE_LO], EXT_UNITS);
    span = (RAM_UNITS - units) << UNIT_LOG2;
    base_d = span[ADDR_W-1:0];
    active_d = ctrl_q[CT_GEN_BIT] & size_q[SZ_EN_BIT];
    open_d = ctrl_q[CT_OPEN_BIT] & ~ctrl_q[CT_CLOSE_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= RESET_BASE;
      active_q <= 1'b0;
      open_q <= 1'b0;
    end else if (load) begin
      base_q <= base_d;
      active_q <= active_d;
      open_q <= open_d;
    end
  end
endmodule

// File: rtl/tseg_access_gate.sv
module tseg_access_gate #(
  parameter int ADDR_W = 27,
  parameter int DATA_W = 8
) (
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic              cpu_smm,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic [ADDR_W-1:0] base_q,
  input  logic              active_q,
  input  logic              open_q,
  output logic              ram_valid,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata
);
  logic in_window;
  logic blocked;

  always_comb begin
    in_window = cpu_addr >= base_q;
    blocked = active_q & in_window & ~cpu_smm & ~open_q;
    ram_valid = cpu_valid & ~blocked;
    ram_we = cpu_we & ram_valid;
    ram_addr = cpu_addr;
    ram_wdata = cpu_wdata;
    cpu_rdata = blocked ? '1 : ram_rdata;
  end
endmodule

// File: rtl/tseg_access_filter.sv
module tseg_access_filter
  import tseg_filter_pkg::*;
#(
  parameter int RAM_UNITS = 128,
  parameter int UNIT_LOG2 = 20,
  parameter int EXT_UNITS = 16,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = $clog2(RAM_UNITS) + UNIT_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  output logic [CFG_W-1:0]  cfg_rdata,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic              cpu_smm,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              ram_valid,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata
);
  localparam int MAX_UNITS  = (EXT_UNITS > 8) ? EXT_UNITS : 8;
  localparam int SAFE_LIMIT = (RAM_UNITS - MAX_UNITS) << UNIT_LOG2;

  logic [CFG_W-1:0]  size_q;
  logic [CFG_W-1:0]  ctrl_q;
  logic              cfg_changed_q;
  logic [ADDR_W-1:0] base_q;
  logic              active_q;
  logic              open_q;

  tseg_cfg_regs regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .size_q(size_q), .ctrl_q(ctrl_q),
    .cfg_changed_q(cfg_changed_q)
  );

  tseg_window_decode #(
    .RAM_UNITS(RAM_UNITS), .UNIT_LOG2(UNIT_LOG2),
    .EXT_UNITS(EXT_UNITS), .ADDR_W(ADDR_W)
  ) decode_i (
    .clk(clk), .rst_n(rst_n), .load(cfg_changed_q), .size_q(size_q),
    .ctrl_q(ctrl_q), .base_q(base_q), .active_q(active_q), .open_q(open_q)
  );

  tseg_access_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) gate_i (
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_smm(cpu_smm),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .base_q(base_q), .active_q(active_q), .open_q(open_q),
    .ram_valid(ram_valid), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  assign cfg_rdata = cfg_sel ? ctrl_q : size_q;
endmodule

// File: rtl/tseg_filter_checker.sv
module tseg_filter_checker #(
  parameter int ADDR_W     = 27,
  parameter int DATA_W     = 8,
  parameter int SAFE_LIMIT = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_valid,
  input logic              cpu_we,
  input logic              cpu_smm,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic [DATA_W-1:0] cpu_rdata,
  input logic              ram_valid,
  input logic [7:0]        size_q,
  input logic [7:0]        ctrl_q
);
  p_blocked_read_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && !cpu_we && !ram_valid |-> cpu_rdata == '1);

  p_smm_reaches_ram_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && cpu_smm |-> ram_valid);

  p_low_ram_passes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && (int'(cpu_addr) < SAFE_LIMIT) |-> ram_valid);

  p_lock_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctrl_q[3]) |-> ctrl_q[3]);

  p_lock_size_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[3] && $past(ctrl_q[3]) |-> $stable(size_q));

  p_inactive_passes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid && !(ctrl_q[0] && size_q[0]) && $past(!(ctrl_q[0] && size_q[0]))
    |-> ram_valid);
endmodule

bind tseg_access_filter tseg_filter_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SAFE_LIMIT(SAFE_LIMIT)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_we(cpu_we),
  .cpu_smm(cpu_smm), .cpu_addr(cpu_addr), .cpu_rdata(cpu_rdata),
  .ram_valid(ram_valid), .size_q(size_q), .ctrl_q(ctrl_q)
);

// File: tb/tseg_access_filter_tb_top.sv
module tseg_access_filter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RAM_UNITS = 32;
  localparam int UNIT_LOG2 = 4;
  localparam int EXT_UNITS = 16;
  localparam int ADDR_W = 9;
  localparam int BYTES = RAM_UNITS << UNIT_LOG2;
  localparam logic [7:0] GEN = 8'h01, CLS = 8'h02, OPN = 8'h04, LCK = 8'h08;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_we, cfg_sel;
  logic [7:0] cfg_wdata, cfg_rdata;
  logic cpu_valid, cpu_we, cpu_smm;
  logic [ADDR_W-1:0] cpu_addr, ram_addr;
  logic [7:0] cpu_wdata, cpu_rdata, ram_wdata, ram_rdata;
  logic ram_valid, ram_we;
  logic [7:0] mem [BYTES];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tseg_access_filter #(
    .RAM_UNITS(RAM_UNITS), .UNIT_LOG2(UNIT_LOG2), .EXT_UNITS(EXT_UNITS),
    .DATA_W(8), .ADDR_W(ADDR_W)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cpu_valid(cpu_valid),
    .cpu_we(cpu_we), .cpu_smm(cpu_smm), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ram_valid(ram_valid),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata)
  );

  assign ram_rdata = mem[ram_addr];
  always @(posedge clk) if (ram_valid && ram_we) mem[ram_addr] <= ram_wdata;

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) & 255);
  endfunction

  function automatic int units_of(input int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 8;
      default: return EXT_UNITS;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic init_mem();
    for (int a = 0; a < BYTES; a++) mem[a] = pat(a);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cfg_we = 0; cfg_sel = 0; cfg_wdata = 0;
    cpu_valid = 0; cpu_we = 0; cpu_smm = 0; cpu_addr = 0; cpu_wdata = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg_wr(input bit sel, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    @(negedge clk);
  endtask

  task automatic cfg_rd(input bit sel, output logic [7:0] d);
    cfg_sel = sel;
    #1 d = cfg_rdata;
  endtask

  task automatic rd(input int a, input bit smm, output logic [7:0] d);
    @(negedge clk);
    cpu_valid = 1; cpu_we = 0; cpu_smm = smm; cpu_addr = ADDR_W'(a);
    #1 d = cpu_rdata;
    cpu_valid = 0;
  endtask

  task automatic wr(input int a, input logic [7:0] d, input bit smm);
    @(negedge clk);
    cpu_valid = 1; cpu_we = 1; cpu_smm = smm; cpu_addr = ADDR_W'(a); cpu_wdata = d;
    @(posedge clk);
    #1 cpu_valid = 0; cpu_we = 0;
  endtask

  task automatic program_locked(input int code, input logic [7:0] ctrl);
    do_reset();
    init_mem();
    cfg_wr(0, 8'((code << 1) | 1));
    cfg_wr(1, ctrl);
    cfg_wr(1, ctrl | LCK);
  endtask

  task automatic sweep(input int base, input bit active, input string req);
    logic [7:0] d;
    int bad = 0;
    int first_a = -1;
    logic [7:0] first_act = 0, first_exp = 0;
    for (int a = 0; a < BYTES; a++) begin
      logic [7:0] e;
      rd(a, 0, d);
      e = (active && a >= base) ? 8'hFF : pat(a);
      if (d !== e) begin
        bad++;
        if (first_a < 0) begin first_a = a; first_act = d; first_exp = e; end
      end
    end
    check(bad == 0, req, first_act, first_exp);
  endtask

  initial begin
    logic [7:0] d;
    int base;
    do_reset();
    init_mem();
    // R1: reset state and no filtering
    cfg_rd(0, d); check(d == 8'h00, "R1 size reg", d, 0);
    cfg_rd(1, d); check(d == 8'h00, "R1 ctrl reg", d, 0);
    sweep(0, 0, "R1 sweep");

    for (int code = 0; code < 4; code++) begin
      base = (RAM_UNITS - units_of(code)) << UNIT_LOG2;
      program_locked(code, GEN | CLS);
      sweep(base, 1, (code == 3) ? "R3 ext window sweep" : "R2 window sweep");
      wr(base - 1, 8'h01, 0);
      rd(base - 1, 0, d); check(d == 8'h01, "R4 byte below base", d, 1);
      wr(base, 8'h01, 0);
      rd(base, 0, d); check(d == 8'hFF, "R6 blocked write reads ones", d, 8'hFF);
      rd(base, 1, d); check(d == pat(base), "R6 write dropped smm view", d, pat(base));
      rd(BYTES - 1, 1, d); check(d == pat(BYTES - 1), "R8 smm top byte", d, pat(BYTES - 1));
      wr(BYTES - 1, 8'hA5, 1);
      rd(BYTES - 1, 1, d); check(d == 8'hA5, "R8 smm write lands", d, 8'hA5);
      rd(BYTES - 1, 0, d); check(d == 8'hFF, "R5 non-smm top read", d, 8'hFF);
    end

    // R7: both enables required
    do_reset(); init_mem();
    cfg_wr(0, 8'h01); cfg_wr(1, CLS);
    rd(BYTES - 1, 0, d); check(d == pat(BYTES - 1), "R7 global enable clear", d, pat(BYTES - 1));
    do_reset();
    cfg_wr(0, 8'h00); cfg_wr(1, GEN | CLS);
    rd(BYTES - 1, 0, d); check(d == pat(BYTES - 1), "R7 segment enable clear", d, pat(BYTES - 1));

    // R9: open / close combinations
    do_reset();
    cfg_wr(0, 8'h03);
    cfg_wr(1, GEN | OPN);
    rd(BYTES - 2, 0, d); check(d == pat(BYTES - 2), "R9 open passes", d, pat(BYTES - 2));
    cfg_wr(1, GEN | OPN | CLS);
    rd(BYTES - 2, 0, d); check(d == 8'hFF, "R9 open and close blocks", d, 8'hFF);
    cfg_wr(1, GEN);
    rd(BYTES - 2, 0, d); check(d == 8'hFF, "R9 neither blocks", d, 8'hFF);

    // R10: lock freezes controls
    program_locked(1, GEN | CLS);
    base = (RAM_UNITS - 2) << UNIT_LOG2;
    cfg_wr(0, 8'h04);
    cfg_rd(0, d); check(d == 8'h03, "R10 size write ignored", d, 3);
    rd(base - 1, 0, d); check(d == pat(base - 1), "R10 base unchanged below", d, pat(base - 1));
    cfg_wr(1, 8'h00);
    cfg_rd(1, d); check(d == 8'h09, "R10 lock and gen kept, close writable", d, 9);
    cfg_wr(1, OPN);
    cfg_rd(1, d); check(d == 8'h09, "R10 open write ignored", d, 9);
    rd(base, 0, d); check(d == 8'hFF, "R10 still blocked", d, 8'hFF);

    // R11: one-cycle configuration latency
    do_reset(); init_mem();
    cfg_wr(0, 8'h01);
    @(negedge clk);
    cfg_we = 1; cfg_sel = 1; cfg_wdata = GEN | CLS;
    @(negedge clk);
    cfg_we = 0;
    cpu_valid = 1; cpu_we = 0; cpu_smm = 0; cpu_addr = ADDR_W'(BYTES - 1);
    #1 d = cpu_rdata;
    check(d == pat(BYTES - 1), "R11 old setting one cycle", d, pat(BYTES - 1));
    @(negedge clk);
    #1 d = cpu_rdata;
    check(d == 8'hFF, "R11 new setting next cycle", d, 8'hFF);
    cpu_valid = 0;

    // R12: readback masking
    do_reset();
    cfg_wr(0, 8'hFF);
    cfg_rd(0, d); check(d == 8'h07, "R12 size readback", d, 7);
    cfg_wr(1, 8'hF6);
    cfg_rd(1, d); check(d == 8'h06, "R12 ctrl readback", d, 6);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule